// File: doc/BRIEF.md
# Double-to-unsigned truncating converter

This block turns one IEEE-754 double-precision number into an unsigned integer, always rounding toward zero. The number is taken from the low 64 bits of a 128-bit operand; the upper half plays no part. The integer is either 32 or 64 bits wide. The wide form is used only when the 64-bit mode flag and the width select are both high. Otherwise the result is 32 bits, and it leaves the upper half of the 64-bit output at zero.

A number whose truncated value does not fit the chosen width gives the all-ones pattern of that width and raises the invalid flag. This covers NaN, both infinities, anything whose truncation is -1 or below, and anything of 2^w or more. When a fractional part is dropped, the inexact flag is raised, but only if the invalid flag is low. The interface is registered: an operand presented with `in_valid` appears on the outputs one cycle later, with `out_valid` high for that cycle.

Top module: `dbl2uint_trunc`

## Requirements
- R1: Bits [127:64] of `src_opnd` have no effect on `result`, `invalid` or `inexact`; the double is bits [63:0] (sign bit 63, biased exponent bits [62:52], fraction bits [51:0]).
- R2: A finite positive value that fits the width yields its integer part, rounded toward zero.
- R3: The width is 64 only when `long_mode` and `wide_sel` are both 1. Otherwise it is 32, `result[63:32]` is 0, and `wide_sel` has no effect when `long_mode` is 0.
- R4: A value of 2^w or more (w = 32 or 64) sets `invalid` and returns 2^w-1 in the low w bits (upper 32 bits 0 when w = 32).
- R5: NaN and both infinities (exponent field 2047) set `invalid` and return all ones in w bits.
- R6: A negative value whose truncation is -1 or below is invalid and returns all ones. A value strictly between -1 and 0 returns 0 with `inexact` set.
- R7: +0 and -0 return 0 with no flag set. Nonzero subnormals (exponent field 0) return 0 with `inexact` set.
- R8: `inexact` is set exactly when a valid conversion drops a nonzero fractional part.
- R9: `inexact` is 0 whenever `invalid` is 1.
- R10: Results and flags are registered in the cycle after `in_valid`. `out_valid` is high for exactly one cycle per accepted input, including back-to-back inputs. All outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| src_opnd | input | 128 | Source operand; low 64 bits hold the double |
| long_mode | input | 1 | 64-bit mode flag |
| wide_sel | input | 1 | Requests a 64-bit result (only honoured in 64-bit mode) |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Unsigned integer, zero-extended |
| invalid | output | 1 | Value not representable in the chosen width |
| inexact | output | 1 | Fractional part lost |

## Verification
Two conditions can occur in the same cycle: the range check and the detection of a dropped fraction. A value such as 2^32 + 0.5 converted at 32 bits both overflows and has a fraction. The bench drives such values on purpose, and random exponents are clustered near the 2^32 and 2^64 limits. In these cases the range check must win: `invalid` high, the all-ones result, and `inexact` low. The same value converted at 64 bits must give 2^32 with `inexact` high.

// File: rtl/dbl2uint_trunc.sv
module dbl2uint_trunc (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [127:0] src_opnd,
  input  logic         long_mode,
  input  logic         wide_sel,
  output logic         out_valid,
  output logic [63:0]  result,
  output logic         invalid,
  output logic         inexact
);
  logic        sgn;
  logic [10:0] bexp;
  logic [51:0] frac;
  logic [52:0] sig;
  logic        w64;
  logic        special, tiny, big_enough;
  logic [10:0] rsh_full;
  logic [5:0]  rsh;
  logic [127:0] fx;
  logic        ovf;
  logic [63:0] mag;
  logic        bad, lost;
  logic [63:0] sat;
  logic [63:0] nxt_res;

  assign sgn  = src_opnd[63];
  assign bexp = src_opnd[62:52];
  assign frac = src_opnd[51:0];
  assign sig  = {1'b1, frac};
  assign w64  = long_mode & wide_sel;

  assign special    = (bexp == 11'h7FF);
  assign tiny       = (bexp < 11'd1023);
  assign big_enough = w64 ? (bexp >= 11'd1087) : (bexp >= 11'd1055);

  assign rsh_full = 11'd1086 - bexp;
  assign rsh      = rsh_full[5:0];
  assign fx       = {sig, 75'b0} >> rsh;
  assign ovf      = big_enough;

  assign bad = special | (!tiny & sgn) | ovf;

  always_comb begin
    mag  = 64'd0;
    lost = 1'b0;
    if (bexp == 11'd0) begin
      lost = (frac != 52'd0);
    end else if (tiny) begin
      lost = 1'b1;
    end else begin
      mag  = fx[127:64];
      lost = |fx[63:0];
    end
  end

  assign sat     = w64 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
  assign nxt_res = bad ? sat : (w64 ? mag : {32'd0, mag[31:0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= 64'd0;
      invalid   <= 1'b0;
      inexact   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= nxt_res;
        invalid <= bad;
        inexact <= lost & !bad;
      end
    end
  end
endmodule

// File: rtl/dbl2uint_trunc_chk.sv
module dbl2uint_trunc_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [127:0] src_opnd,
  input logic         long_mode,
  input logic         wide_sel,
  input logic         out_valid,
  input logic [63:0]  result,
  input logic         invalid,
  input logic         inexact
);
  assert_invalid_mutes_inexact_R9: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> !inexact);

  assert_strobe_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_strobe_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_narrow_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(long_mode && wide_sel)) |=> (result[63:32] == 32'd0));

  assert_nan_inf_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_opnd[62:52] == 11'h7FF) |=> invalid);

  assert_zero_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_opnd[62:0] == 63'd0) |=> (result == 64'd0 && !invalid && !inexact));

  assert_saturate_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && invalid) |-> (result[31:0] == 32'hFFFF_FFFF));
endmodule

bind dbl2uint_trunc dbl2uint_trunc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_opnd(src_opnd),
  .long_mode(long_mode), .wide_sel(wide_sel), .out_valid(out_valid),
  .result(result), .invalid(invalid), .inexact(inexact)
);

// File: tb/dbl2uint_trunc_bench.sv
module dbl2uint_trunc_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] src_opnd = '0;
  logic         long_mode = 1'b0;
  logic         wide_sel = 1'b0;
  logic         out_valid;
  logic [63:0]  result;
  logic         invalid;
  logic         inexact;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dbl2uint_trunc u_dbl2uint_trunc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_opnd(src_opnd),
    .long_mode(long_mode), .wide_sel(wide_sel), .out_valid(out_valid),
    .result(result), .invalid(invalid), .inexact(inexact)
  );

  function automatic logic [65:0] model(input logic [63:0] d, input logic lm, input logic ws);
    logic w = lm & ws;
    logic s = d[63];
    int   e = int'(d[62:52]);
    logic [63:0] sg = {11'd0, 1'b1, d[51:0]};
    logic [63:0] r = 0;
    logic inv = 0, inx = 0;
    int lim = w ? 1087 : 1055;
    if (e == 2047) inv = 1;
    else if (e == 0) inx = (d[51:0] != 0);
    else if (e < 1023) inx = 1;
    else if (s) inv = 1;
    else if (e >= lim) inv = 1;
    else if (e >= 1075) r = sg << (e - 1075);
    else begin
      r   = sg >> (1075 - e);
      inx = (sg & ((64'd1 << (1075 - e)) - 64'd1)) != 0;
    end
    if (inv) begin
      r   = w ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
      inx = 0;
    end
    return {r, inv, inx};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run1(input logic [127:0] op, input logic lm, input logic ws, input string req);
    logic [65:0] m;
    m = model(op[63:0], lm, ws);
    @(negedge clk);
    src_opnd = op; long_mode = lm; wide_sel = ws; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " out_valid R10"}, {63'd0, out_valid}, 64'd1);
    chk({req, " result"}, result, m[65:2]);
    chk({req, " flags"}, {62'd0, invalid, inexact}, {62'd0, m[1:0]});
  endtask

  task automatic expect_val(input logic [127:0] op, input logic lm, input logic ws,
                            input logic [63:0] er, input logic ei, input logic ex, input string req);
    @(negedge clk);
    src_opnd = op; long_mode = lm; wide_sel = ws; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " result"}, result, er);
    chk({req, " flags"}, {62'd0, invalid, inexact}, {62'd0, ei, ex});
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    chk("reset R10 outputs", {result[63:2], out_valid, invalid | inexact}, 64'd0);
    rst_n = 1'b1;

    expect_val({64'd0, 64'h0000_0000_0000_0000}, 1, 1, 64'd0, 0, 0, "R7 +0");
    expect_val({64'd0, 64'h8000_0000_0000_0000}, 1, 1, 64'd0, 0, 0, "R7 -0");
    expect_val({64'd0, 64'h0000_0000_0000_0001}, 0, 0, 64'd0, 0, 1, "R7 subnormal");
    expect_val({64'd0, 64'h3FF8_0000_0000_0000}, 0, 0, 64'd1, 0, 1, "R2 R8 1.5");
    expect_val({64'd0, 64'h3FF0_0000_0000_0000}, 0, 0, 64'd1, 0, 0, "R2 1.0");
    expect_val({64'd0, 64'hBFE0_0000_0000_0000}, 1, 1, 64'd0, 0, 1, "R6 -0.5");
    expect_val({64'd0, 64'hBFF0_0000_0000_0000}, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, "R6 -1.0");
    expect_val({64'd0, 64'h41EF_FFFF_FFE0_0000}, 0, 0, 64'h0000_0000_FFFF_FFFF, 0, 0, "R2 2^32-1");
    expect_val({64'd0, 64'h41F0_0000_0000_0000}, 0, 0, 64'h0000_0000_FFFF_FFFF, 1, 0, "R4 2^32 narrow");
    expect_val({64'd0, 64'h41F0_0000_0000_0000}, 0, 1, 64'h0000_0000_FFFF_FFFF, 1, 0, "R3 width ignored");
    expect_val({64'd0, 64'h41F0_0000_0000_0000}, 1, 0, 64'h0000_0000_FFFF_FFFF, 1, 0, "R3 long narrow");
    expect_val({64'd0, 64'h41F0_0000_0000_0000}, 1, 1, 64'h0000_0001_0000_0000, 0, 0, "R3 2^32 wide");
    expect_val({64'd0, 64'h41F0_0000_0008_0000}, 0, 0, 64'h0000_0000_FFFF_FFFF, 1, 0, "R9 2^32+.5 narrow");
    expect_val({64'd0, 64'h41F0_0000_0008_0000}, 1, 1, 64'h0000_0001_0000_0000, 0, 1, "R8 2^32+.5 wide");
    expect_val({64'd0, 64'h43EF_FFFF_FFFF_FFFF}, 1, 1, 64'hFFFF_FFFF_FFFF_F800, 0, 0, "R2 max wide");
    expect_val({64'd0, 64'h43F0_0000_0000_0000}, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, "R4 2^64");
    expect_val({64'd0, 64'h7FF8_0000_0000_0000}, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, "R5 NaN");
    expect_val({64'd0, 64'h7FF0_0000_0000_0000}, 0, 0, 64'h0000_0000_FFFF_FFFF, 1, 0, "R5 +inf");
    expect_val({64'd0, 64'hFFF0_0000_0000_0000}, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, "R5 -inf");
    expect_val({64'hDEAD_BEEF_0123_4567, 64'h4059_0000_0000_0000}, 1, 1, 64'd100, 0, 0, "R1 upper junk");

    @(negedge clk);
    chk("R10 strobe drops", {63'd0, out_valid}, 64'd0);

    @(negedge clk);
    src_opnd = {64'd0, 64'h4000_0000_0000_0000}; long_mode = 1; wide_sel = 1; in_valid = 1;
    @(negedge clk);
    chk("R10 b2b first", result, 64'd2);
    src_opnd = {64'd0, 64'h4008_0000_0000_0000};
    @(negedge clk);
    in_valid = 0;
    chk("R10 b2b second", result, 64'd3);
    chk("R10 b2b strobe", {63'd0, out_valid}, 64'd1);

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] d;
      logic [10:0] e;
      d = {$urandom, $urandom};
      case ($urandom % 4)
        0: e = 11'd1010 + 11'($urandom % 30);
        1: e = 11'd1050 + 11'($urandom % 10);
        2: e = 11'd1070 + 11'($urandom % 20);
        default: e = d[62:52];
      endcase
      d[62:52] = e;
      run1({$urandom, $urandom, $urandom, $urandom, d} >> 0, 1'($urandom), 1'($urandom),
           "R2 R4 R6 R8 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule